// File: doc/BRIEF.md
# Combinable Accumulator Operate Unit

This block holds a 12-bit accumulator and a 1-bit link flag and updates them one instruction at a time. An instruction word may request several micro-operations at once, each in its own bit. Within one instruction the block applies them in a fixed order: the clears first, then the complements, then the increment, and the rotate last. The rotate acts on the 13-bit ring formed by the link above the accumulator. It can move the ring by one or two places, in either direction.

The same datapath also performs the accumulate step of a memory add instruction. The operand word supplied with the instruction is added into the accumulator modulo 4096. A carry out of the top accumulator bit inverts the link. A sequencer drives the instruction word and the operand, and raises the strobe for one cycle for each instruction. The new accumulator and link values appear on the outputs after the next clock edge.

Top module: `accum_op_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted instruction, `acc` is 0 and `link` is 0.
- R2: When `strobe` is low, or when the word belongs to neither recognised class, `acc` and `link` keep their values.
- R3: Classes use `instr[11:9]`. The value 3'b111 with `instr[8]`=0 is an operate word; 3'b001 is an add word. Operate fields are: `instr[7]` clear acc, `instr[6]` clear link, `instr[5]` complement acc, `instr[4]` complement link, `instr[3]` rotate right, `instr[2]` rotate left, `instr[1]` rotate by two, `instr[0]` increment.
- R4: Clears act before complements. Clear acc together with complement acc gives 12'hFFF. Clear link together with complement link gives link 1.
- R5: The increment acts after the complements. It adds 1 to the accumulator, and a carry out of bit 11 inverts the link. For example, complement acc with increment gives the two's-complement negative.
- R6: A single rotate acts last, on the 13-bit ring {link, acc}. Left moves acc[11] into link and link into acc[0]. Right moves acc[0] into link and link into acc[11].
- R7: When `instr[1]` is set with exactly one direction bit, the ring rotates two places in that direction.
- R8: When both direction bits are set, or when `instr[1]` is set with no direction bit, the ring is not rotated. All other requested micro-operations still apply.
- R9: An add word sets acc to (acc + `operand`) mod 4096 and inverts the link when the sum carries out of bit 11.
- R10: The result of an instruction strobed in one cycle is visible on `acc` and `link` after the next rising clock edge. A new instruction may be strobed in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Execute the presented instruction this cycle |
| instr | input | 12 | Instruction word |
| operand | input | 12 | Operand for add words |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link flag |

## Verification
The embedded properties check the following on every cycle:
- The state holds when no recognised instruction is strobed.
- A rotate-only operate word preserves the number of ones in the 13-bit ring.
- A lone clear yields zero.
- Complement-plus-increment negates the accumulator.
- The link on an add flips exactly when the accumulator wraps below its previous value.

Only the bench scenarios can show the exact bit placement of one- and two-place rotates in each direction. They also cover the precedence among combined micro-operations, the ignored rotate encodings, and the increment carry at 12'hFFF. Each of these is compared against a reference model over directed and random words.

// File: rtl/accum_op_unit.sv
module accum_op_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [11:0]  instr,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         link
);
  localparam int RW = W + 1;

  logic is_op, is_add;
  assign is_op  = (instr[11:9] == 3'b111) && !instr[8];
  assign is_add = (instr[11:9] == 3'b001);

  logic         f_cla, f_cll, f_cma, f_cml, f_rr, f_rl, f_two, f_iac;
  assign {f_cla, f_cll, f_cma, f_cml, f_rr, f_rl, f_two, f_iac} = instr[7:0];

  logic [W-1:0] a_clr, a_cmp;
  logic         l_clr, l_cmp, l_inc;
  logic [RW-1:0] inc_sum, ring, ring_out, add_sum;

  assign a_clr   = f_cla ? '0 : acc;
  assign l_clr   = f_cll ? 1'b0 : link;
  assign a_cmp   = f_cma ? ~a_clr : a_clr;
  assign l_cmp   = f_cml ? ~l_clr : l_clr;
  assign inc_sum = {1'b0, a_cmp} + RW'(f_iac);
  assign l_inc   = l_cmp ^ inc_sum[W];
  assign ring    = {l_inc, inc_sum[W-1:0]};

  always_comb begin
    unique case ({f_rl, f_rr, f_two})
      3'b100:  ring_out = {ring[RW-2:0], ring[RW-1]};
      3'b101:  ring_out = {ring[RW-3:0], ring[RW-1:RW-2]};
      3'b010:  ring_out = {ring[0], ring[RW-1:1]};
      3'b011:  ring_out = {ring[1:0], ring[RW-1:2]};
      default: ring_out = ring;
    endcase
  end

  assign add_sum = {1'b0, acc} + {1'b0, operand};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      link <= 1'b0;
    end else if (strobe && is_op) begin
      acc  <= ring_out[W-1:0];
      link <= ring_out[W];
    end else if (strobe && is_add) begin
      acc  <= add_sum[W-1:0];
      link <= link ^ add_sum[W];
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && (instr[11:9] == 3'b001 || (instr[11:8] == 4'b1110)))
      |=> $stable(acc) && $stable(link));

  p_ring_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[11:8] == 4'b1110 && instr[7:4] == 4'b0000 && !instr[0])
      |=> $countones({link, acc}) == $countones($past({link, acc})));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[11:8] == 4'b1110 && instr[7] && !instr[5] && !instr[0]
     && instr[3:2] == 2'b00) |=> acc == '0);

  p_negate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr == 12'o7041)
      |=> (acc == W'(-$past(acc))) && ((link != $past(link)) == ($past(acc) == '0)));

  p_add_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && instr[11:9] == 3'b001)
      |=> (link != $past(link)) == (acc < $past(acc)));
endmodule

// File: tb/accum_op_unit_test.sv
module accum_op_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] operand = '0;
  logic [11:0] acc;
  logic        link;

  int vectors = 0;
  int errors  = 0;
  logic [11:0] m_acc = '0;
  logic        m_link = 1'b0;

  always #2 clk = ~clk;

  accum_op_unit #(.W(12)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .instr(instr),
    .operand(operand), .acc(acc), .link(link)
  );

  function automatic logic [12:0] model(input logic [11:0] a, input logic l,
                                        input logic [11:0] w, input logic [11:0] d,
                                        input logic s);
    logic [12:0] r;
    int steps;
    if (!s) return {l, a};
    if (w[11:9] == 3'b001) begin
      r = {1'b0, a} + {1'b0, d};
      return {l ^ r[12], r[11:0]};
    end
    if (w[11:8] != 4'b1110) return {l, a};
    if (w[7]) a = 12'h000;
    if (w[6]) l = 1'b0;
    if (w[5]) a = ~a;
    if (w[4]) l = ~l;
    if (w[0]) begin
      if (a == 12'hFFF) l = ~l;
      a = a + 12'd1;
    end
    r = {l, a};
    steps = w[1] ? 2 : 1;
    if (w[2] && !w[3]) begin
      for (int i = 0; i < steps; i++) r = {r[11:0], r[12]};
    end else if (w[3] && !w[2]) begin
      for (int i = 0; i < steps; i++) r = {r[0], r[12:1]};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [11:0] ea, input logic el);
    vectors++;
    if (acc !== ea || link !== el) begin
      errors++;
      $display("FAIL %s: acc=%h link=%b expected acc=%h link=%b", tag, acc, link, ea, el);
    end
  endtask

  task automatic step(input logic [11:0] w, input logic [11:0] d, input logic s,
                      input string tag);
    logic [12:0] exp;
    @(negedge clk);
    instr = w; operand = d; strobe = s;
    exp = model(m_acc, m_link, w, d, s);
    @(posedge clk);
    #1;
    m_acc = exp[11:0]; m_link = exp[12];
    check(tag, m_acc, m_link);
  endtask

  task automatic load(input logic [11:0] v, input logic l);
    step(12'o7300, 12'h000, 1'b1, "R4 setup clear");
    step(12'o1000, v, 1'b1, "R9 setup load");
    if (l) step(12'o7020, 12'h000, 1'b1, "R4 setup link");
  endtask

  initial begin
    void'($urandom(32'd5521));
    #1;
    check("R1 in reset", 12'h000, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(12'o7001, 12'h000, 1'b0, "R1 after release");

    load(12'h5A3, 1'b1);
    step(12'o7001, 12'h000, 1'b0, "R2 strobe low");
    step(12'o7400, 12'hFFF, 1'b1, "R2 bit8 set ignored");
    step(12'o2000, 12'hFFF, 1'b1, "R2 other class ignored");

    step(12'o7240, 12'h000, 1'b1, "R4 clear+complement acc");
    step(12'o7120, 12'h000, 1'b1, "R4 clear+complement link");

    load(12'h00C, 1'b0);
    step(12'o7041, 12'h000, 1'b1, "R5 negate");
    load(12'hFFF, 1'b0);
    step(12'o7001, 12'h000, 1'b1, "R5 increment carry");
    step(12'o7041, 12'h000, 1'b1, "R5 negate zero");

    load(12'h801, 1'b0);
    step(12'o7004, 12'h000, 1'b1, "R6 rotate left");
    step(12'o7010, 12'h000, 1'b1, "R6 rotate right");
    step(12'o7011, 12'h000, 1'b1, "R6 increment then rotate");
    load(12'hC03, 1'b1);
    step(12'o7006, 12'h000, 1'b1, "R7 rotate left two");
    step(12'o7012, 12'h000, 1'b1, "R7 rotate right two");
    step(12'o7014, 12'h000, 1'b1, "R8 both directions");
    step(12'o7002, 12'h000, 1'b1, "R8 two without direction");
    step(12'o7217, 12'h000, 1'b1, "R8 both directions with clear+inc");

    load(12'h800, 1'b0);
    step(12'o1000, 12'h800, 1'b1, "R9 add carry");
    step(12'o1000, 12'h123, 1'b1, "R9 add no carry");

    step(12'o1000, 12'h001, 1'b1, "R10 back-to-back a");
    step(12'o7001, 12'h000, 1'b1, "R10 back-to-back b");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] w;
      logic [3:0] sel;
      sel = 4'($urandom);
      if (sel < 4'd9)       w = {4'b1110, 8'($urandom)};
      else if (sel < 4'd13) w = {3'b001, 9'($urandom)};
      else                  w = 12'($urandom);
      step(w, 12'($urandom), ($urandom % 8) != 0, "R3 random mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: acc=%h link=%b expected run to finish", acc, link);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule